// File: doc/BRIEF.md
# Serial 1101 Sequence Recognizer with Moore and Mealy Flags

This block watches a serial bit stream, one bit per rising clock edge, and flags every occurrence of the four-bit sequence 1, 1, 0, 1 in arrival order. Overlapping occurrences are found. One occurrence can supply the leading 1 of the next.

Two small state machines read the same input bit side by side. The Mealy machine raises its flag combinationally, in the cycle where the closing 1 is present on the input. The Moore machine raises its flag from its state register alone, one cycle later. A consumer picks the flag whose timing suits it. It can take the early flag, which has an input-to-output path, or the late flag, which is glitch-free and registered.

Top module: `pattern_1101_detector`

## Requirements
- R1: A match is the bit sequence 1, 1, 0, 1 sampled on four consecutive rising edges, oldest bit first; no other four-bit history produces a match.
- R2: The Moore machine uses state codes 000 (nothing seen), 001 (1), 010 (11), 011 (110) and 100 (match). `moore_hit` is 1 exactly when the state is 100, which is the cycle after the edge that sampled the closing 1.
- R3: `mealy_hit` is 1 in the cycle where the last three sampled bits are 1, 1, 0 and `bit_in` currently carries 1. The Mealy machine uses states 00, 01, 10 and 11, and 11 means 110 has been seen.
- R4: `mealy_hit` is 0 whenever `bit_in` is 0.
- R5: Every `mealy_hit` pulse is followed on the next cycle by a `moore_hit` pulse, and `moore_hit` is never 1 unless `mealy_hit` was 1 one cycle earlier.
- R6: Reset is synchronous and active high. While `rst` is 1 both flags read 0. The edge that samples `rst` returns the machines to 000 and 00, so bits taken before reset never complete a match afterwards.
- R7: Matches overlap. After a match, the final 1 counts as the first bit of the next attempt, so the stream 1101101 yields two match pulses on each flag. Neither flag is ever 1 on two consecutive cycles.
- R8: `moore_hit` has no combinational path from `bit_in`. Changing `bit_in` within a cycle leaves `moore_hit` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit, sampled each rising edge |
| moore_hit | output | 1 | Match flag decoded from the Moore state register |
| mealy_hit | output | 1 | Match flag from the Mealy state and the present input |

## Verification
A closing 1 raises the Mealy flag in the same cycle in which the Moore flag still reports the previous state. In an overlapping stream such as 1101101, the Moore flag for one match can therefore coincide with the Mealy machine advancing toward the next match. The bench provokes this with an exhaustive sweep of every 8-bit stream after reset and with a long pseudo-random stream. A shift-register model predicts the Mealy flag from the three stored bits plus the live bit, and the Moore flag as that prediction delayed by one cycle. Inside each cycle the bench flips the input and checks that the Moore flag does not move while the Mealy flag follows the input.

// File: rtl/p1101_pkg.sv
package p1101_pkg;
  localparam int MOORE_W = 3;
  localparam int MEALY_W = 2;

  typedef enum logic [MOORE_W-1:0] {
    MO_IDLE = 3'b000,
    MO_G1   = 3'b001,
    MO_G11  = 3'b010,
    MO_G110 = 3'b011,
    MO_HIT  = 3'b100
  } moore_st_t;

  typedef enum logic [MEALY_W-1:0] {
    ME_IDLE = 2'b00,
    ME_G1   = 2'b01,
    ME_G11  = 2'b10,
    ME_G110 = 2'b11
  } mealy_st_t;
endpackage

// File: rtl/p1101_moore_fsm.sv
module p1101_moore_fsm
  import p1101_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  moore_st_t st_q, st_d;

  always_comb begin
    case (st_q)
      MO_IDLE: st_d = din ? MO_G1  : MO_IDLE;
      MO_G1:   st_d = din ? MO_G11 : MO_IDLE;
      MO_G11:  st_d = din ? MO_G11 : MO_G110;
      MO_G110: st_d = din ? MO_HIT : MO_IDLE;
      MO_HIT:  st_d = din ? MO_G11 : MO_IDLE;
      default: st_d = MO_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= MO_IDLE;
    else     st_q <= st_d;
  end

  // decoded from the register only: no path from din
  assign hit = (st_q == MO_HIT);
endmodule

// File: rtl/p1101_mealy_fsm.sv
module p1101_mealy_fsm
  import p1101_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  mealy_st_t st_q, st_d;

  always_comb begin
    case (st_q)
      ME_IDLE: st_d = din ? ME_G1  : ME_IDLE;
      ME_G1:   st_d = din ? ME_G11 : ME_IDLE;
      ME_G11:  st_d = din ? ME_G11 : ME_G110;
      ME_G110: st_d = din ? ME_G1  : ME_IDLE;
      default: st_d = ME_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ME_IDLE;
    else     st_q <= st_d;
  end

  assign hit = (st_q == ME_G110) && din;
endmodule

// File: rtl/pattern_1101_detector.sv
module pattern_1101_detector (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic moore_hit,
  output logic mealy_hit
);
  logic moore_raw, mealy_raw;

  p1101_moore_fsm u_moore (
    .clk (clk),
    .rst (rst),
    .din (bit_in),
    .hit (moore_raw)
  );

  p1101_mealy_fsm u_mealy (
    .clk (clk),
    .rst (rst),
    .din (bit_in),
    .hit (mealy_raw)
  );

  // both flags held low for as long as reset is applied
  assign moore_hit = moore_raw && !rst;
  assign mealy_hit = mealy_raw && !rst;
endmodule

// File: rtl/p1101_checker.sv
module p1101_checker (
  input logic clk,
  input logic rst,
  input logic bit_in,
  input logic moore_hit,
  input logic mealy_hit
);
  // R4
  p_mealy_needs_one_r4: assert property (@(posedge clk) disable iff (rst)
    mealy_hit |-> bit_in);

  // R5
  p_moore_follows_mealy_r5: assert property (@(posedge clk) disable iff (rst)
    mealy_hit |=> moore_hit);

  // R5
  p_moore_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
    moore_hit |-> $past(mealy_hit));

  // R6
  p_moore_clear_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !moore_hit);

  // R7
  p_moore_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    moore_hit |=> !moore_hit);

  // R7
  p_mealy_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    mealy_hit |=> !mealy_hit);
endmodule

bind pattern_1101_detector p1101_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_in    (bit_in),
  .moore_hit (moore_hit),
  .mealy_hit (mealy_hit)
);

// File: tb/tb_pattern_1101_detector.sv
`timescale 1ns/1ps
module tb_pattern_1101_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic moore_hit, mealy_hit;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [2:0] hist = 3'b000;   // last three sampled bits, newest in bit 0
  logic exp_moore = 1'b0;      // delayed model of the Mealy prediction
  logic last_mealy = 1'b0;     // Mealy flag seen in the previous cycle
  int moore_pulses = 0;

  always #2 clk = ~clk;        // 250 MHz

  pattern_1101_detector dut (
    .clk(clk), .rst(rst), .bit_in(bit_in),
    .moore_hit(moore_hit), .mealy_hit(mealy_hit)
  );

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock cycle: drive b (with reset r), check, then let the edge happen
  task automatic step(input logic b, input logic r);
    logic exp_mealy, m_before;
    @(negedge clk);
    rst = r;
    bit_in = b;
    exp_mealy = !r && ({hist, b} == 4'b1101);
    #0.5;
    m_before = moore_hit;
    bit_in = ~b;
    #0.5;
    check(moore_hit == m_before, "R8 moore stable when input flips", moore_hit, m_before);
    bit_in = b;
    #0.5;
    check(mealy_hit == exp_mealy, "R3/R1 mealy flag", mealy_hit, exp_mealy);
    check(moore_hit == (!r && exp_moore), "R2/R1 moore flag", moore_hit, !r && exp_moore);
    if (r) begin
      check(!moore_hit && !mealy_hit, "R6 flags low in reset", moore_hit | mealy_hit, 1'b0);
    end else begin
      check(moore_hit == last_mealy, "R5 moore lags mealy", moore_hit, last_mealy);
      if (!b) check(!mealy_hit, "R4 mealy low on zero input", mealy_hit, 1'b0);
      check(!(moore_hit && last_mealy && mealy_hit), "R7 no back-to-back mealy",
            mealy_hit, 1'b0);
    end
    if (moore_hit) moore_pulses++;
    last_mealy = r ? 1'b0 : mealy_hit;
    @(posedge clk);
    if (r) begin
      hist = 3'b000;
      exp_moore = 1'b0;
    end else begin
      hist = {hist[1:0], b};
      exp_moore = exp_mealy;
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [6:0] seq;
    // reset state (R6)
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);

    // R7: overlapping stream 1101101 plus one trailing zero
    seq = 7'b1101101;
    moore_pulses = 0;
    for (int i = 6; i >= 0; i--) step(seq[i], 1'b0);
    step(1'b0, 1'b0);
    checks++;
    if (moore_pulses != 2) begin
      errors++;
      $display("FAIL R7 overlap pulse count actual=%0d expected=2", moore_pulses);
    end

    // R6: 110 before reset, then 1 after reset must not match
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);

    // R1: exhaustive sweep of every 8-bit stream from reset
    for (int v = 0; v < 256; v++) begin
      step(1'b0, 1'b1);
      for (int i = 7; i >= 0; i--) step(v[i], 1'b0);
      step(1'b0, 1'b0);
    end

    // long pseudo-random stream, biased toward ones, with occasional resets
    for (int n = 0; n < 3000; n++) begin
      int unsigned rv;
      rv = $urandom;
      step((rv % 3) != 0, (rv % 211) == 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule